// File: doc/BRIEF.md
# Receive CRC Error Disposition Filter

This block sits on the receive side of an Ethernet MAC, after the byte deserializer. Each frame arrives as a byte stream with start and end markers, and the input cannot be stalled. The block checks the frame's CRC-32 and stores the bytes in a small packet FIFO. A downstream packet port with valid/ready handshaking drains the FIFO. Three policy bits decide what happens to a frame whose CRC fails:

- forward it as a good frame;
- forward it marked bad, with or without an error strobe on its last beat;
- drop it inside the FIFO, so that none of its bytes leave.

A short frame is held until its CRC verdict is known. A frame that grows past a programmable transfer threshold starts leaving the FIFO early. From that point it can still be flagged, but it can no longer be dropped.

Two saturating counters can be cleared together. One counts frames with a bad CRC. The other counts FIFO overflows. If a held frame overflows the FIFO, the frame is discarded. If a frame that is already streaming out overflows, it is cut short with an error end-of-frame.

Top module: `rx_crc_disp`

## Requirements
- R1: Every input end-of-frame byte whose CRC check fails adds exactly one to `fcs_err_cnt_o`, under every policy setting. The counter saturates at its all-ones value, and `cnt_clr_i` clears it (and `ovf_cnt_o`) to zero on the next cycle.
- R2: When `cfg_pass_i`=1, a frame with a bad CRC is forwarded in full with `out_bad_o`=0 and `out_err_o`=0. The other two policy bits have no effect.
- R3: When `cfg_pass_i`=0 and `cfg_drop_i`=1, a bad-CRC frame whose length (FCS included) is not above `cfg_thresh_i` is removed inside the FIFO. None of its bytes appear at the output.
- R4: When `cfg_pass_i`=0, `cfg_drop_i`=0 and `cfg_strobe_i`=1, a bad-CRC frame is forwarded in full. Its end-of-frame beat carries `out_bad_o`=1 and `out_err_o`=1.
- R5: When `cfg_pass_i`=0, `cfg_drop_i`=0 and `cfg_strobe_i`=0, a bad-CRC frame is forwarded in full. Its end-of-frame beat carries `out_bad_o`=1 and `out_err_o`=0.
- R6: A frame longer than `cfg_thresh_i` bytes is never dropped for a bad CRC, even when `cfg_drop_i`=1. With `cfg_pass_i`=0, its last beat carries `out_bad_o`=1 and `out_err_o`=`cfg_strobe_i`. Its first byte may leave before its last byte has been received.
- R7: The CRC is Ethernet CRC-32: polynomial 0x04C11DB7, initial value all ones, reflected bit order, FCS sent least significant byte first. A frame is good when the remainder over data plus FCS equals the fixed residue 0xC704DD7B, which the reflected register holds as 0xDEBB20E3. Good frames come out unchanged and in order, with `out_sof_o` on the first beat, `out_eof_o` on the last beat, and `out_bad_o`=`out_err_o`=0.
- R8: A frame whose length is not above `cfg_thresh_i` presents no byte at the output before its end-of-frame byte has been received.
- R9: While `out_valid_o`=1 and `out_ready_i`=0, the output beat holds steady. `out_bad_o` and `out_err_o` are 0 on every beat that does not carry `out_eof_o`, and `out_err_o`=1 implies `out_bad_o`=1.
- R10: A byte of a held frame arriving when fewer than two FIFO entries are free causes the whole frame to be discarded and adds one to `ovf_cnt_o`. Later frames are received normally.
- R11: A byte of a frame that has already started streaming, arriving when fewer than two entries are free, is written as an end-of-frame beat with `out_bad_o`=1 and `out_err_o`=1. The rest of that frame is discarded, and `ovf_cnt_o` increments by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte present |
| in_data_i | input | 8 | Input byte |
| in_sof_i | input | 1 | First byte of a frame |
| in_eof_i | input | 1 | Last byte of a frame (last FCS byte) |
| cfg_pass_i | input | 1 | Forward bad-CRC frames as good |
| cfg_drop_i | input | 1 | Drop held bad-CRC frames |
| cfg_strobe_i | input | 1 | Raise error strobe on bad frames |
| cfg_thresh_i | input | LEN_W | Transfer threshold in bytes |
| cnt_clr_i | input | 1 | Clear both counters |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Downstream accepts beat |
| out_data_o | output | 8 | Output byte |
| out_sof_o | output | 1 | Output first beat |
| out_eof_o | output | 1 | Output last beat |
| out_bad_o | output | 1 | Frame marked bad (last beat only) |
| out_err_o | output | 1 | Error strobe (last beat only) |
| fcs_err_cnt_o | output | CNT_W | Bad-CRC frame count |
| ovf_cnt_o | output | CNT_W | FIFO overflow count |

## Verification
The in-RTL assertions cover the rules that hold on every cycle:

- each counter step, saturation hold and clear;
- the FIFO never holding more than its depth;
- a rewind only ever returning to the committed boundary, so no byte that has been released is taken back;
- the output beat staying steady under back-pressure;
- the error and bad flags appearing only on end-of-frame beats.

The policy matrix needs the bench's scenarios. It checks which frames disappear, which are flagged, and with which strobe, across all eight policy settings, for good and bad CRC and for held and cut-through lengths. The bench also checks the timing of the first output byte against the input end-of-frame, and both overflow outcomes.

// File: rtl/rx_crc_pkg.sv
package rx_crc_pkg;

  typedef struct packed {
    logic       sof;
    logic       eof;
    logic       bad;
    logic       err;
    logic [7:0] data;
  } rx_ent_t;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT      = 32'hFFFFFFFF;
  // 0xC704DD7B held in reflected register order
  localparam logic [31:0] CRC_RESIDUE   = 32'hDEBB20E3;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/rx_crc32.sv
module rx_crc32
  import rx_crc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       sof_i,
  input  logic [7:0] data_i,
  output logic       ok_o
);

  logic [31:0] crc_q, crc_d;

  assign crc_d = crc_step(sof_i ? CRC_INIT : crc_q, data_i);
  assign ok_o  = (crc_d == CRC_RESIDUE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= CRC_INIT;
    else if (en_i) crc_q <= crc_d;
  end

endmodule

// File: rtl/rx_sat_cnt.sv
module rx_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (inc_i && cnt_q != MAX) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && cnt_q != MAX) |=> cnt_q == $past(cnt_q) + W'(1)); // R1
  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_q == MAX) |=> cnt_q == MAX); // R1
  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(cnt_q)); // R1
  AST_CNT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0); // R1

endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo
  import rx_crc_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  rx_ent_t       wr_ent_i,
  input  logic          commit_i,
  input  logic          rewind_i,
  input  logic [PW-1:0] rewind_ptr_i,
  output logic [PW-1:0] wp_o,
  output logic [PW-1:0] free_o,
  output logic          rd_valid_o,
  output rx_ent_t       rd_ent_o,
  input  logic          rd_i
);

  rx_ent_t       mem_q [DEPTH];
  logic [PW-1:0] wp_q, cp_q, rp_q, wp_d;

  assign wp_d       = rewind_i ? rewind_ptr_i : (wr_i ? wp_q + PW'(1) : wp_q);
  assign wp_o       = wp_q;
  assign free_o     = PW'(DEPTH) - (wp_q - rp_q);
  assign rd_valid_o = (rp_q != cp_q);
  assign rd_ent_o   = mem_q[rp_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wp_q[AW-1:0]] <= wr_ent_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      cp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      if (commit_i) cp_q <= wp_d;
      if (rd_i)     rp_q <= rp_q + PW'(1);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp_q - rp_q) <= PW'(DEPTH)); // R10
  AST_COMMIT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_q - rp_q) <= (wp_q - rp_q)); // R8
  AST_REWIND_UNCOMMITTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rewind_i |-> rewind_ptr_i == cp_q); // R6
  AST_READ_COMMITTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> rp_q != cp_q); // R8

endmodule

// File: rtl/rx_crc_disp.sv
module rx_crc_disp
  import rx_crc_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LEN_W = 12,
  parameter int CNT_W = 32,
  localparam int PW = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  input  logic             in_sof_i,
  input  logic             in_eof_i,
  input  logic             cfg_pass_i,
  input  logic             cfg_drop_i,
  input  logic             cfg_strobe_i,
  input  logic [LEN_W-1:0] cfg_thresh_i,
  input  logic             cnt_clr_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [7:0]       out_data_o,
  output logic             out_sof_o,
  output logic             out_eof_o,
  output logic             out_bad_o,
  output logic             out_err_o,
  output logic [CNT_W-1:0] fcs_err_cnt_o,
  output logic [CNT_W-1:0] ovf_cnt_o
);

  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic             in_frame_q, discard_q, cut_q;
  logic [LEN_W-1:0] len_q, cur_len;
  logic [PW-1:0]    start_q, start_ptr, wp, free;
  logic             crc_ok, acc, room, cut_prev, cut_now;
  logic             fifo_wr, fifo_commit, fifo_rewind, ovf_inc, fcs_inc, rd;
  rx_ent_t          wr_ent, rd_ent;

  rx_crc32 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (in_valid_i),
    .sof_i  (in_sof_i),
    .data_i (in_data_i),
    .ok_o   (crc_ok)
  );

  assign acc       = in_valid_i && (in_sof_i || (in_frame_q && !discard_q));
  assign room      = free >= PW'(2);
  assign cut_prev  = !in_sof_i && cut_q;
  assign cur_len   = in_sof_i ? LEN_W'(1) : ((len_q == LEN_MAX) ? len_q : len_q + LEN_W'(1));
  assign cut_now   = cut_prev || (cur_len > cfg_thresh_i);
  assign start_ptr = in_sof_i ? wp : start_q;

  always_comb begin
    fifo_wr     = 1'b0;
    fifo_commit = 1'b0;
    fifo_rewind = 1'b0;
    ovf_inc     = 1'b0;
    wr_ent      = '0;
    wr_ent.data = in_data_i;
    wr_ent.sof  = in_sof_i;
    wr_ent.eof  = in_eof_i;
    if (acc) begin
      if (room) begin
        if (in_eof_i && !crc_ok && !cfg_pass_i) begin
          if (cfg_drop_i && !cut_now) begin
            fifo_rewind = 1'b1;
          end else begin
            fifo_wr     = 1'b1;
            fifo_commit = 1'b1;
            wr_ent.bad  = 1'b1;
            wr_ent.err  = cfg_strobe_i;
          end
        end else begin
          fifo_wr     = 1'b1;
          fifo_commit = in_eof_i || cut_now;
        end
      end else begin
        ovf_inc = 1'b1;
        if (cut_prev) begin
          // part already released: close it with an error beat
          fifo_wr     = 1'b1;
          fifo_commit = 1'b1;
          wr_ent.eof  = 1'b1;
          wr_ent.bad  = 1'b1;
          wr_ent.err  = 1'b1;
        end else begin
          fifo_rewind = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      discard_q  <= 1'b0;
      cut_q      <= 1'b0;
      len_q      <= '0;
      start_q    <= '0;
    end else if (in_valid_i) begin
      if (in_sof_i) begin
        in_frame_q <= 1'b1;
        discard_q  <= 1'b0;
        start_q    <= wp;
      end
      if (acc) begin
        len_q <= cur_len;
        cut_q <= cut_now;
        if (!room) discard_q <= 1'b1;
      end
      if (in_eof_i) begin
        in_frame_q <= 1'b0;
        discard_q  <= 1'b0;
      end
    end
  end

  rx_pkt_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (fifo_wr),
    .wr_ent_i     (wr_ent),
    .commit_i     (fifo_commit),
    .rewind_i     (fifo_rewind),
    .rewind_ptr_i (start_ptr),
    .wp_o         (wp),
    .free_o       (free),
    .rd_valid_o   (out_valid_o),
    .rd_ent_o     (rd_ent),
    .rd_i         (rd)
  );

  assign rd         = out_valid_o && out_ready_i;
  assign out_data_o = rd_ent.data;
  assign out_sof_o  = rd_ent.sof;
  assign out_eof_o  = rd_ent.eof;
  assign out_bad_o  = rd_ent.bad;
  assign out_err_o  = rd_ent.err;

  assign fcs_inc = in_valid_i && in_eof_i && !crc_ok;

  rx_sat_cnt #(.W(CNT_W)) u_fcs_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr_i),
    .inc_i  (fcs_inc),
    .cnt_o  (fcs_err_cnt_o)
  );

  rx_sat_cnt #(.W(CNT_W)) u_ovf_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr_i),
    .inc_i  (ovf_inc),
    .cnt_o  (ovf_cnt_o)
  );

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)
      && $stable(out_sof_o) && $stable(out_eof_o) && $stable(out_err_o))); // R9
  AST_FLAGS_AT_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && (out_bad_o || out_err_o)) |-> out_eof_o); // R9
  AST_ERR_IS_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_err_o) |-> out_bad_o); // R4
  AST_PASS_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_wr && cfg_pass_i && room) |-> !wr_ent.bad); // R2

endmodule

// File: tb/rx_crc_disp_tb_top.sv
`timescale 1ns/1ps
module rx_crc_disp_tb_top;

  localparam int DEPTH = 16;
  localparam int LEN_W = 8;
  localparam int CNT_W = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic in_valid = 0, in_sof = 0, in_eof = 0;
  logic [7:0] in_data = 0;
  logic cfg_pass = 0, cfg_drop = 0, cfg_strobe = 0, cnt_clr = 0;
  logic [LEN_W-1:0] cfg_thresh = 8;
  logic out_valid, out_ready = 1'b0, out_sof, out_eof, out_bad, out_err;
  logic [7:0] out_data;
  logic [CNT_W-1:0] fcs_cnt, ovf_cnt;

  always #2.5 clk = ~clk;

  rx_crc_disp #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_sof_i(in_sof), .in_eof_i(in_eof), .cfg_pass_i(cfg_pass), .cfg_drop_i(cfg_drop),
    .cfg_strobe_i(cfg_strobe), .cfg_thresh_i(cfg_thresh), .cnt_clr_i(cnt_clr),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_sof_o(out_sof), .out_eof_o(out_eof), .out_bad_o(out_bad), .out_err_o(out_err),
    .fcs_err_cnt_o(fcs_cnt), .ovf_cnt_o(ovf_cnt)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, eof_cyc = 0, first_cyc = 0;
  int ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] fr [64];
  int fr_n = 0;
  logic [7:0] rx_d [64];
  logic rx_sof [64], rx_eof [64], rx_bad [64], rx_err [64];
  int rx_n = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    #1 out_ready = (ready_mode == 2) ? lfsr[0] : (ready_mode == 1);
  end

  always @(negedge clk) begin
    if (rst_ni && out_valid && out_ready) begin
      if (rx_n == 0) first_cyc = cyc;
      if (rx_n < 64) begin
        rx_d[rx_n] = out_data; rx_sof[rx_n] = out_sof; rx_eof[rx_n] = out_eof;
        rx_bad[rx_n] = out_bad; rx_err[rx_n] = out_err;
      end
      rx_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fcs_of(input int n);
    logic [31:0] c, r;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++)
        c = {c[30:0], 1'b0} ^ ((c[31] ^ fr[i][k]) ? 32'h04C11DB7 : 32'h0);
    for (int j = 0; j < 32; j++) r[j] = c[31-j];
    return ~r;
  endfunction

  task automatic build(input int plen, input int seed, input bit corrupt);
    logic [31:0] f;
    for (int i = 0; i < plen; i++) fr[i] = 8'((seed * 13 + i * 7 + 3) & 255);
    f = fcs_of(plen);
    for (int b = 0; b < 4; b++) fr[plen+b] = f[8*b +: 8];
    fr_n = plen + 4;
    if (corrupt) fr[fr_n-1] = fr[fr_n-1] ^ 8'h01;
  endtask

  task automatic send();
    rx_n = 0;
    for (int i = 0; i < fr_n; i++) begin
      @(posedge clk); #1;
      in_valid = 1; in_data = fr[i]; in_sof = (i == 0); in_eof = (i == fr_n - 1);
      if (i == fr_n - 1) eof_cyc = cyc;
    end
    @(posedge clk); #1;
    in_valid = 0; in_sof = 0; in_eof = 0;
  endtask

  task automatic drain();
    ready_mode = 1;
    repeat (40) @(posedge clk);
    #1;
  endtask

  // timing: 0 none, 1 held (R8), 2 cut-through (R6)
  task automatic check_frame(input bit present, input bit bad, input bit err,
                             input int timing, input string tag);
    int bad_data;
    if (!present) begin
      chk(rx_n == 0, {tag, " frame dropped"}, rx_n, 0);
      return;
    end
    chk(rx_n == fr_n, {tag, " beat count"}, rx_n, fr_n);
    if (rx_n != fr_n) return;
    bad_data = 0;
    for (int i = 0; i < fr_n; i++) begin
      if (rx_d[i] != fr[i] || rx_sof[i] != (i == 0) || rx_eof[i] != (i == fr_n - 1)) bad_data++;
      if (i != fr_n - 1 && (rx_bad[i] || rx_err[i])) bad_data++;
    end
    chk(bad_data == 0, {tag, " R9 data/markers"}, bad_data, 0);
    chk(rx_bad[fr_n-1] == bad, {tag, " bad flag"}, int'(rx_bad[fr_n-1]), int'(bad));
    chk(rx_err[fr_n-1] == err, {tag, " err strobe"}, int'(rx_err[fr_n-1]), int'(err));
    if (timing == 1) chk(first_cyc > eof_cyc, "R8 held until eof", first_cyc, eof_cyc + 1);
    if (timing == 2) chk(first_cyc <= eof_cyc, "R6 early release", first_cyc, eof_cyc);
  endtask

  task automatic clear_cnt();
    @(posedge clk); #1 cnt_clr = 1;
    @(posedge clk); #1 cnt_clr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int plens [3];
    int nbad, exp_cnt;
    plens[0] = 2; plens[1] = 4; plens[2] = 12;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    @(negedge clk);
    chk(out_valid == 0, "R9 reset out_valid", int'(out_valid), 0);
    chk(fcs_cnt == 0 && ovf_cnt == 0, "R1 reset counters", int'(fcs_cnt), 0);
    ready_mode = 1;
    cfg_thresh = 8;

    // policy sweep: all 8 settings x good/bad x held/cut lengths
    for (int cfg = 0; cfg < 8; cfg++) begin
      cfg_pass = cfg[2]; cfg_drop = cfg[1]; cfg_strobe = cfg[0];
      clear_cnt();
      nbad = 0;
      for (int k = 0; k < 3; k++) begin
        for (int c = 0; c < 2; c++) begin
          bit cut, gone, b;
          string tag;
          build(plens[k], cfg * 6 + k * 2 + c, c[0]);
          cut  = (fr_n > 8);
          b    = c[0] && !cfg_pass;
          gone = b && cfg_drop && !cut;
          if (!c[0])          tag = "R7";
          else if (cfg_pass)  tag = "R2";
          else if (cut)       tag = "R6";
          else if (cfg_drop)  tag = "R3";
          else if (cfg_strobe) tag = "R4";
          else                tag = "R5";
          send();
          drain();
          check_frame(!gone, b, b && cfg_strobe, gone ? 0 : (cut ? 2 : 1), tag);
          if (c) nbad++;
          exp_cnt = (nbad > 15) ? 15 : nbad;
          chk(fcs_cnt == CNT_W'(exp_cnt), "R1 fcs count", int'(fcs_cnt), exp_cnt);
        end
      end
    end

    // saturation and clear
    cfg_pass = 0; cfg_drop = 1; cfg_strobe = 0;
    clear_cnt();
    for (int i = 0; i < 17; i++) begin
      build(1, i, 1'b1);
      send();
    end
    drain();
    chk(rx_n == 0, "R3 back-to-back drops", rx_n, 0);
    chk(fcs_cnt == 15, "R1 saturation", int'(fcs_cnt), 15);
    clear_cnt();
    @(negedge clk);
    chk(fcs_cnt == 0, "R1 clear", int'(fcs_cnt), 0);

    // back-pressure
    cfg_pass = 0; cfg_drop = 0; cfg_strobe = 1;
    for (int i = 0; i < 4; i++) begin
      build(6 + i, 50 + i, i[0]);
      ready_mode = 2;
      send();
      repeat (20) @(posedge clk);
      drain();
      check_frame(1'b1, i[0], i[0], 0, "R9 stall");
    end

    // held-frame overflow
    clear_cnt();
    cfg_thresh = 200;
    ready_mode = 0;
    repeat (2) @(posedge clk);
    build(16, 77, 1'b0);
    send();
    drain();
    chk(rx_n == 0, "R10 overflowed frame dropped", rx_n, 0);
    chk(ovf_cnt == 1, "R10 overflow count", int'(ovf_cnt), 1);
    build(3, 78, 1'b0);
    send();
    drain();
    check_frame(1'b1, 1'b0, 1'b0, 1, "R10 recovery");

    // cut-through overflow: 15 bytes fit, 16th becomes error eof
    clear_cnt();
    cfg_thresh = 2;
    ready_mode = 0;
    repeat (2) @(posedge clk);
    build(16, 91, 1'b0);
    send();
    drain();
    chk(rx_n == 16, "R11 truncated beats", rx_n, 16);
    if (rx_n == 16) begin
      int mism = 0;
      for (int i = 0; i < 16; i++)
        if (rx_d[i] != fr[i] || rx_eof[i] != (i == 15)) mism++;
      chk(mism == 0, "R11 truncated data", mism, 0);
      chk(rx_bad[15] && rx_err[15], "R11 error eof", int'(rx_err[15]), 1);
    end
    chk(ovf_cnt == 1, "R11 overflow count", int'(ovf_cnt), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule